// File: doc/BRIEF.md
# Graceful Transmit Stop Controller

This block pauses and resumes a frame-based transmitter at a safe point. Software holds a stop-request level. If no frame is on the wire when the request arrives, the transmitter halts on the next clock. If a frame is on the wire, that frame is allowed to finish. A frame that a collision cuts short also counts as a finish. Once the transmitter has halted, a stop-complete interrupt fires and the launch of new frames or retries stays blocked.

The controller sits between the transmit scheduler and the frame engine. The scheduler offers a queued frame with `frame_ready_i`. The controller answers with `frame_start_o` only when starting a frame is allowed. After a collision the frame engine asks for a retry with `retry_req_i`, and the controller grants it only while running freely. Dropping the stop request restarts transmission with the next queued frame. A sticky flag records each completed stop until software writes a one to clear it.

Top module: `gts_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `halted_o`, `tx_active_o`, `stop_irq_o` and `stop_flag_o` are all 0, and the controller is in the running state.
- R2: A stop request seen while no frame is active takes the controller to the halted state on the next clock edge (`halted_o` = 1).
- R3: A stop request seen while a frame is active (and the frame is not ending in that cycle) leaves `halted_o` at 0 until the frame ends. `halted_o` rises on the clock edge that samples `frame_done_i`, and `halted_o` and `tx_active_o` are never 1 together.
- R4: A frame that ends with `frame_coll_i` while a stop is requested is a stopping point: `halted_o` rises on that edge. No retry is granted (`retry_grant_o` = 0) while the stop request is high or while halted. While running with no request and no active frame, `retry_grant_o` follows `retry_req_i`.
- R5: `frame_start_o` is 1 only when `frame_ready_i` is 1, the stop request is 0, the controller is running, and no frame is active. It is 0 while a stop is pending or halted.
- R6: Entering the halted state raises `stop_irq_o` for exactly one cycle, the first cycle in which `halted_o` is 1, and sets `stop_flag_o` in the same cycle.
- R7: A 1 on `stat_clr_i` clears `stop_flag_o` on the next edge. When a set and a clear arrive on the same edge, the set wins.
- R8: Dropping the stop request while halted returns the controller to running on the next edge. The next offered frame is then started.
- R9: Dropping the stop request while a stop is pending returns the controller to running without a stop-complete interrupt, and the active frame continues.
- R10: A frame becomes active (`tx_active_o` = 1) on the edge after a `frame_start_o` or `retry_grant_o` grant. It stops being active on the edge that samples `frame_done_i` or `frame_coll_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_i | input | 1 | Software stop-request level |
| frame_ready_i | input | 1 | A queued frame is ready to launch |
| frame_done_i | input | 1 | Active frame completed normally (one-cycle pulse) |
| frame_coll_i | input | 1 | Active frame aborted by collision (one-cycle pulse) |
| retry_req_i | input | 1 | Frame engine asks to retransmit after a collision |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the stop flag |
| frame_start_o | output | 1 | Grant to launch the offered frame |
| retry_grant_o | output | 1 | Grant to launch a retry |
| tx_active_o | output | 1 | A frame is on the wire |
| halted_o | output | 1 | Transmitter is stopped |
| stop_irq_o | output | 1 | One-cycle stop-complete interrupt |
| stop_flag_o | output | 1 | Sticky stop-complete status |

## Verification
The assertions assume that the frame engine sends `frame_done_i` and `frame_coll_i` only while a frame is active, never both in one cycle, and never in the same cycle as a grant. They also assume that `retry_req_i` arrives only when no frame is active. Under those rules, the active flag and the stop state machine cannot disagree about where a frame ends. The stimulus table and the directed tests raise an end pulse only in the cycles after a grant and before the next grant. Retries are requested only after the frame has ended.

// File: rtl/gts_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the graceful stop controller.
// Assumes: nothing beyond the three states below.
package gts_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN     = 2'd0,
        ST_PENDING = 2'd1,
        ST_STOPPED = 2'd2
    } gts_state_t;
endpackage

// File: rtl/gts_frame_track.sv
`timescale 1ns/1ps
// Module: gts_frame_track
// Tracks whether a frame is on the wire. A launch (start or retry) sets
// the flag, and a normal end or a collision end clears it.
// Assumes: an end pulse never coincides with a launch.
module gts_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic end_i,
    output logic active_o
);
    logic active_q;

    // Purpose: hold the frame-active flag between launch and end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (launch_i)
            active_q <= 1'b1;
        else if (end_i)
            active_q <= 1'b0;
    end

    assign active_o = active_q;
endmodule

// File: rtl/gts_fsm.sv
`timescale 1ns/1ps
// Module: gts_fsm
// Stop state machine: RUN, PENDING (waiting for the active frame to end),
// STOPPED. It flags the cycle in which STOPPED is entered.
// Assumes: end_i is only meaningful while active_i is high.
module gts_fsm
    import gts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req_i,
    input  logic       active_i,
    input  logic       end_i,
    output gts_state_t state_o,
    output logic       enter_stop_o
);
    gts_state_t state_q, state_d;

    // Purpose: compute the next stop state from the request and frame end.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req_i)
                    state_d = (active_i && !end_i) ? ST_PENDING : ST_STOPPED;
            end
            ST_PENDING: begin
                if (!stop_req_i)
                    state_d = ST_RUN;
                else if (end_i)
                    state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (!stop_req_i)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Purpose: register the stop state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    assign state_o      = state_q;
    assign enter_stop_o = (state_d == ST_STOPPED) && (state_q != ST_STOPPED);
endmodule

// File: rtl/gts_status.sv
`timescale 1ns/1ps
// Module: gts_status
// Produces the one-cycle stop-complete interrupt and the sticky flag.
// The flag is cleared by a write-one strobe, and a set wins over a clear.
// Assumes: set_i is high for a single cycle per stop.
module gts_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o,
    output logic flag_o
);
    logic irq_q;
    logic flag_q;

    // Purpose: register the interrupt pulse for the entry cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= set_i;
    end

    // Purpose: sticky flag, where a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign irq_o  = irq_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/gts_ctrl.sv
`timescale 1ns/1ps
// Module: gts_ctrl (top)
// Graceful transmit stop controller. It gates frame and retry launches,
// lets an active frame finish (or end on a collision) before halting,
// and reports completion through an interrupt pulse and a sticky flag.
// Assumes: the frame engine sends one end pulse per launched frame.
module gts_ctrl
    import gts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_i,
    input  logic frame_ready_i,
    input  logic frame_done_i,
    input  logic frame_coll_i,
    input  logic retry_req_i,
    input  logic stat_clr_i,
    output logic frame_start_o,
    output logic retry_grant_o,
    output logic tx_active_o,
    output logic halted_o,
    output logic stop_irq_o,
    output logic stop_flag_o
);
    gts_state_t state_q;
    logic       active;
    logic       frame_end;
    logic       launch_ok;
    logic       enter_stop;

    assign frame_end = frame_done_i | frame_coll_i;

    // Purpose: a launch is allowed only when running freely and idle.
    always_comb begin
        launch_ok = (state_q == ST_RUN) && !stop_req_i && !active;
    end

    assign frame_start_o = launch_ok && frame_ready_i;
    assign retry_grant_o = launch_ok && retry_req_i;

    gts_frame_track i_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (frame_start_o | retry_grant_o),
        .end_i    (frame_end),
        .active_o (active)
    );

    gts_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req_i   (stop_req_i),
        .active_i     (active),
        .end_i        (frame_end),
        .state_o      (state_q),
        .enter_stop_o (enter_stop)
    );

    gts_status i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (enter_stop),
        .clr_i  (stat_clr_i),
        .irq_o  (stop_irq_o),
        .flag_o (stop_flag_o)
    );

    assign tx_active_o = active;
    assign halted_o    = (state_q == ST_STOPPED);
endmodule

// File: rtl/gts_ctrl_checker.sv
`timescale 1ns/1ps
// Module: gts_ctrl_checker
// Concurrent properties for gts_ctrl, attached through bind.
module gts_ctrl_checker
    import gts_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input gts_state_t state,
    input logic       stop_req_i,
    input logic       frame_done_i,
    input logic       stat_clr_i,
    input logic       frame_start_o,
    input logic       retry_grant_o,
    input logic       tx_active_o,
    input logic       halted_o,
    input logic       stop_irq_o,
    input logic       stop_flag_o
);
    a_r2_idle_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req_i && !tx_active_o) |=> halted_o);

    a_r3_no_halt_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active_o |-> !halted_o);

    a_r3_halt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PENDING && stop_req_i && frame_done_i) |=> (halted_o && stop_irq_o));

    a_r4_no_retry_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !retry_grant_o);

    a_r5_no_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !frame_start_o);

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq_o |=> !stop_irq_o);

    a_r6_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq_o |-> (stop_flag_o && halted_o));

    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i && halted_o) |=> !stop_flag_o);

    a_r9_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PENDING && !stop_req_i) |=> (!stop_irq_o && state == ST_RUN));

    a_r10_launch_active: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o || retry_grant_o) |=> tx_active_o);
endmodule

bind gts_ctrl gts_ctrl_checker i_gts_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .stop_req_i    (stop_req_i),
    .frame_done_i  (frame_done_i),
    .stat_clr_i    (stat_clr_i),
    .frame_start_o (frame_start_o),
    .retry_grant_o (retry_grant_o),
    .tx_active_o   (tx_active_o),
    .halted_o      (halted_o),
    .stop_irq_o    (stop_irq_o),
    .stop_flag_o   (stop_flag_o)
);

// File: tb/test_gts_ctrl.sv
`timescale 1ns/1ps
module test_gts_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req_i = 0, frame_ready_i = 0, frame_done_i = 0;
    logic frame_coll_i = 0, retry_req_i = 0, stat_clr_i = 0;
    logic frame_start_o, retry_grant_o, tx_active_o, halted_o, stop_irq_o, stop_flag_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    gts_ctrl i_gts_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req_i),
        .frame_ready_i(frame_ready_i), .frame_done_i(frame_done_i),
        .frame_coll_i(frame_coll_i), .retry_req_i(retry_req_i),
        .stat_clr_i(stat_clr_i), .frame_start_o(frame_start_o),
        .retry_grant_o(retry_grant_o), .tx_active_o(tx_active_o),
        .halted_o(halted_o), .stop_irq_o(stop_irq_o), .stop_flag_o(stop_flag_o)
    );

    // Vector: stop,ready,done,coll,retry,clr | start,grant (before edge)
    //         | active,halted,irq,flag (after edge)
    localparam int NV = 21;
    localparam logic [11:0] VEC [NV] = '{
        12'b010000_10_1000, // R5 start from idle run
        12'b010000_00_1000, // R5 ready while active: no start
        12'b100000_00_1000, // R3 stop mid-frame -> pending
        12'b110000_00_1000, // R5 ready ignored while pending
        12'b101000_00_0111, // R3 done -> halted, irq, flag
        12'b110000_00_0101, // R6 irq single cycle, R5 gated
        12'b100001_00_0100, // R7 clear flag
        12'b010000_00_0000, // R8 release: resume
        12'b010000_10_1000, // R8 next frame starts
        12'b000100_00_0000, // R10 collision ends frame in run
        12'b000010_01_1000, // R4 retry granted when running
        12'b100100_00_0111, // R4 collision with stop -> halted
        12'b100010_00_0101, // R4 retry refused while halted
        12'b000001_00_0000, // R8 release and clear
        12'b010000_10_1000, // R10 start
        12'b100000_00_1000, // R9 pending
        12'b000000_00_1000, // R9 cancel, no irq
        12'b001000_00_0000, // R10 done ends frame
        12'b110000_00_0111, // R2 idle stop halts at once
        12'b100000_00_0101, // R6 irq gone
        12'b000000_00_0001  // R8 resume, flag kept
    };

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] v);
        @(negedge clk);
        {stop_req_i, frame_ready_i, frame_done_i, frame_coll_i, retry_req_i, stat_clr_i} = v;
    endtask

    task automatic settle_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 halted", halted_o, 0);
        chk("R1 active", tx_active_o, 0);
        chk("R1 irq", stop_irq_o, 0);
        chk("R1 flag", stop_flag_o, 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            drive(v[11:6]);
            #0.5;
            chk($sformatf("R5 start v%0d", i), frame_start_o, v[5]);
            chk($sformatf("R4 grant v%0d", i), retry_grant_o, v[4]);
            settle_edge();
            chk($sformatf("R10 active v%0d", i), tx_active_o, v[3]);
            chk($sformatf("R3 halted v%0d", i), halted_o, v[2]);
            chk($sformatf("R6 irq v%0d", i), stop_irq_o, v[1]);
            chk($sformatf("R7 flag v%0d", i), stop_flag_o, v[0]);
        end

        // R7: set and clear on the same edge -> set wins (flag is still 1).
        drive(6'b100001);
        settle_edge();
        chk("R7 set beats clear halted", halted_o, 1);
        chk("R7 set beats clear flag", stop_flag_o, 1);
        chk("R6 irq on entry", stop_irq_o, 1);

        // R1: reset from the halted state clears everything.
        drive(6'b100000);
        rst_n = 1'b0;
        settle_edge();
        chk("R1 reset halted", halted_o, 0);
        chk("R1 reset flag", stop_flag_o, 0);
        chk("R1 reset irq", stop_irq_o, 0);
        drive(6'b010000);
        rst_n = 1'b1;
        #0.5;
        chk("R1 run after reset start", frame_start_o, 1);
        settle_edge();
        chk("R10 active after reset start", tx_active_o, 1);
        drive(6'b001000);
        settle_edge();
        chk("R10 done clears active", tx_active_o, 0);
        drive(6'b000000);
        settle_edge();

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule